// File: doc/BRIEF.md
# Programmable Machine-Cycle Clock Controller

This block turns one fast reference clock into the clock-enable pulses that an 8-bit microcontroller core runs on. The reference runs at four times the crystal rate, so the faster multiplied rates are available as enables of the reference. No analog multiplier is needed.

Software writes a 2-bit rate field and a multiplier-depth bit through a one-cycle write strobe. The block produces two kinds of output:
- `sysclk_en`, a system-clock enable at the selected rate, which timers and peripherals use.
- `mc_state` and `mc_end`, a four-state machine-cycle counter and an end-of-cycle strobe, which the instruction engine uses.

A new rate never takes effect in the middle of a machine cycle. It is held as pending and applied only on a later machine-cycle boundary. At that point the prescaler starts from zero, so no partial system-clock period is ever produced.

Top module: `mcc_clkctl`

## Requirements
- R1: When `rst_n` is low, the block enters pass-through mode with `wr_mul4` equal to 0, `mc_state` equal to 0 and nothing pending. After `rst_n` is released, the first `sysclk_en` pulse is present after the third rising edge.
- R2: Rate code 2'b10 (pass-through) asserts `sysclk_en` once every 4 reference cycles. A machine cycle then lasts 16 reference cycles.
- R3: `mc_state` advances by one on every `sysclk_en` and wraps from 3 to 0. It holds its value otherwise. `mc_end` is high exactly on the `sysclk_en` that ends state 3.
- R4: Rate code 2'b00 with `wr_mul4`=1 (four times the crystal rate) asserts `sysclk_en` on every reference cycle. A machine cycle then lasts 4 reference cycles.
- R5: Rate code 2'b00 with `wr_mul4`=0 (twice the crystal rate) asserts `sysclk_en` once every 2 reference cycles. A machine cycle then lasts 8 reference cycles.
- R6: A written selection takes effect only after a deferral:
  - The machine cycle in progress at the write finishes at the old rate.
  - The whole machine cycle after it also runs at the old rate.
  - The new rate starts on the reference cycle that ends that following machine cycle.
- R7: A write with rate code 2'b01 is ignored. The rate in effect continues unchanged.
- R8: Rate code 2'b11 asserts `sysclk_en` once every 1024 reference cycles. A machine cycle then lasts 4096 reference cycles.
- R9: A second valid write made before the pending one is applied replaces the pending value and restarts the deferral. Only the last value is ever applied.
- R10: When a new rate is applied, the prescaler restarts. Every machine cycle at the new rate, including the first, therefore contains exactly four `sysclk_en` pulses spaced at the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, four times the crystal rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | One-cycle write strobe for the rate selection |
| wr_div | input | 2 | Rate code: 00 multiplied, 01 reserved, 10 pass-through, 11 slow |
| wr_mul4 | input | 1 | Multiplier depth when rate code is 00: 1 is x4, 0 is x2 |
| sysclk_en | output | 1 | System-clock enable for timers and peripherals |
| mc_state | output | 2 | Machine-cycle state, 0 to 3 |
| mc_end | output | 1 | Strobe on the reference cycle that ends a machine cycle |

## Verification
The assertions check four properties on every cycle:
- the state counter steps or holds in step with the enable;
- the active rate changes only on a machine-cycle boundary, and when it changes it takes the pending value;
- the reserved code never becomes active;
- the x4 mode produces an enable on every reference cycle.

Only the directed scenarios can show the end-to-end timing that follows from these cycle-level rules:
- the measured machine-cycle lengths in each mode;
- the count of one old-rate cycle before a change lands;
- the last-write-wins override;
- the return to defaults after a reset in the middle of a run.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  typedef enum logic [1:0] {
    RATE_MULT = 2'b00,
    RATE_RSVD = 2'b01,
    RATE_PASS = 2'b10,
    RATE_SLOW = 2'b11
  } rate_sel_e;

  typedef struct packed {
    rate_sel_e sel;
    logic      mul4;
  } rate_cfg_t;

  localparam rate_cfg_t CFG_RESET = '{sel: RATE_PASS, mul4: 1'b0};
endpackage

// File: rtl/mcc_rate_cfg.sv
module mcc_rate_cfg
  import mcc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [1:0] wr_div,
  input  logic      wr_mul4,
  input  logic      cyc_end,
  output rate_cfg_t act_cfg,
  output rate_cfg_t pend_cfg,
  output logic      pend_vld,
  output logic      pend_arm
);
  rate_cfg_t act_q, act_d, pend_q, pend_d;
  logic      vld_q, vld_d, arm_q, arm_d;
  logic      wr_ok;

  assign wr_ok = wr_en && (rate_sel_e'(wr_div) != RATE_RSVD);

  always_comb begin
    act_d  = act_q;
    pend_d = pend_q;
    vld_d  = vld_q;
    arm_d  = arm_q;
    if (cyc_end && vld_q) begin
      if (arm_q) begin
        act_d = pend_q;
        vld_d = 1'b0;
        arm_d = 1'b0;
      end else begin
        arm_d = 1'b1;
      end
    end
    if (wr_ok) begin
      pend_d = '{sel: rate_sel_e'(wr_div), mul4: wr_mul4};
      vld_d  = 1'b1;
      arm_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= CFG_RESET;
      pend_q <= CFG_RESET;
      vld_q  <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
      vld_q  <= vld_d;
      arm_q  <= arm_d;
    end
  end

  assign act_cfg  = act_q;
  assign pend_cfg = pend_q;
  assign pend_vld = vld_q;
  assign pend_arm = arm_q;
endmodule

// File: rtl/mcc_prescaler.sv
module mcc_prescaler
  import mcc_pkg::*;
#(
  parameter int P_MUL4 = 1,
  parameter int P_MUL2 = 2,
  parameter int P_PASS = 4,
  parameter int P_SLOW = 1024
) (
  input  logic      clk,
  input  logic      rst_n,
  input  rate_cfg_t act_cfg,
  output logic      tick
);
  localparam int CW = (P_SLOW > 2) ? $clog2(P_SLOW) : 1;

  logic [CW:0]   period;
  logic [CW-1:0] last;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    unique case (act_cfg.sel)
      RATE_MULT: period = act_cfg.mul4 ? (CW+1)'(P_MUL4) : (CW+1)'(P_MUL2);
      RATE_SLOW: period = (CW+1)'(P_SLOW);
      default:   period = (CW+1)'(P_PASS);
    endcase
  end

  assign last = CW'(period - 1'b1);
  assign tick = (cnt_q == last);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mcc_state_gen.sv
module mcc_state_gen #(
  parameter int NSTATE = 4,
  localparam int SW = (NSTATE > 1) ? $clog2(NSTATE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [SW-1:0] state,
  output logic          cyc_end
);
  localparam logic [SW-1:0] LAST = SW'(NSTATE - 1);

  logic [SW-1:0] st_q, st_d;
  logic          at_last;

  assign at_last = (st_q == LAST);
  assign cyc_end = tick && at_last;

  always_comb begin
    st_d = st_q;
    if (tick) st_d = at_last ? '0 : st_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/mcc_clkctl.sv
module mcc_clkctl
  import mcc_pkg::*;
#(
  parameter int P_MUL4 = 1,
  parameter int P_MUL2 = 2,
  parameter int P_PASS = 4,
  parameter int P_SLOW = 1024,
  parameter int NSTATE = 4,
  localparam int SW = (NSTATE > 1) ? $clog2(NSTATE) : 1
) (
  input  logic          clk_ref,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_div,
  input  logic          wr_mul4,
  output logic          sysclk_en,
  output logic [SW-1:0] mc_state,
  output logic          mc_end
);
  rate_cfg_t act_cfg, pend_cfg;
  logic      pend_vld, pend_arm;
  logic      tick;

  mcc_rate_cfg u_cfg (
    .clk(clk_ref), .rst_n(rst_n),
    .wr_en(wr_en), .wr_div(wr_div), .wr_mul4(wr_mul4),
    .cyc_end(mc_end),
    .act_cfg(act_cfg), .pend_cfg(pend_cfg),
    .pend_vld(pend_vld), .pend_arm(pend_arm)
  );

  mcc_prescaler #(
    .P_MUL4(P_MUL4), .P_MUL2(P_MUL2), .P_PASS(P_PASS), .P_SLOW(P_SLOW)
  ) u_pre (
    .clk(clk_ref), .rst_n(rst_n), .act_cfg(act_cfg), .tick(tick)
  );

  mcc_state_gen #(.NSTATE(NSTATE)) u_st (
    .clk(clk_ref), .rst_n(rst_n), .tick(tick),
    .state(mc_state), .cyc_end(mc_end)
  );

  assign sysclk_en = tick;
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker
  import mcc_pkg::*;
#(
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sysclk_en,
  input logic [SW-1:0] state,
  input logic          cyc_end,
  input rate_cfg_t     act_cfg,
  input rate_cfg_t     pend_cfg,
  input logic          pend_vld,
  input logic          pend_arm
);
  AST_STATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sysclk_en |=> state == SW'($past(state) + 1'b1)); // R3
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sysclk_en |=> $stable(state)); // R3
  AST_CFG_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(act_cfg)); // R6
  AST_CFG_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && pend_vld && pend_arm) |=> act_cfg == $past(pend_cfg)); // R6
  AST_NO_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    act_cfg.sel != RATE_RSVD); // R7
  AST_MUL4_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cfg.sel == RATE_MULT && act_cfg.mul4) |-> sysclk_en); // R4
endmodule

bind mcc_clkctl mcc_checker #(.SW(SW)) u_chk (
  .clk(clk_ref), .rst_n(rst_n), .sysclk_en(sysclk_en), .state(mc_state),
  .cyc_end(mc_end), .act_cfg(act_cfg), .pend_cfg(pend_cfg),
  .pend_vld(pend_vld), .pend_arm(pend_arm)
);

// File: tb/sim_mcc_clkctl.sv
module sim_mcc_clkctl;
  localparam time CLK_PER = 10ns;

  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_div;
  logic       wr_mul4;
  logic       sysclk_en;
  logic [1:0] mc_state;
  logic       mc_end;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PER/2) clk_ref = ~clk_ref;

  mcc_clkctl u0 (
    .clk_ref(clk_ref), .rst_n(rst_n), .wr_en(wr_en), .wr_div(wr_div),
    .wr_mul4(wr_mul4), .sysclk_en(sysclk_en), .mc_state(mc_state), .mc_end(mc_end)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_end();
    while (!mc_end) @(negedge clk_ref);
  endtask

  // Measures one machine cycle from the current boundary to the next one.
  task automatic expect_cycle(input string req, input int exp_len);
    int len = 0;
    int ens = 0;
    wait_end();
    do begin
      @(negedge clk_ref);
      len++;
      if (sysclk_en) ens++;
    end while (!mc_end);
    check(len == exp_len, req, len, exp_len);
    check(ens == 4, {req, " R10 enables per cycle"}, ens, 4);
    check(mc_state == 2'd3 && sysclk_en, "R3 end strobe in state 3", int'(mc_state), 3);
  endtask

  task automatic write_now(input logic [1:0] dv, input logic m4);
    wr_en = 1'b1; wr_div = dv; wr_mul4 = m4;
    @(negedge clk_ref);
    wr_en = 1'b0;
  endtask

  task automatic write_sel(input logic [1:0] dv, input logic m4);
    wait_end();
    @(negedge clk_ref);
    write_now(dv, m4);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk_ref);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    int n = 0;
    do_reset();
    check(mc_state == 2'd0, "R1 state after reset", int'(mc_state), 0);
    check(sysclk_en == 1'b0, "R1 no enable at release", int'(sysclk_en), 0);
    while (!sysclk_en) begin
      @(negedge clk_ref);
      n++;
    end
    check(n == 3, "R1 first enable edge", n, 3);
  endtask

  task automatic t_default();
    expect_cycle("R2 pass-through", 16);
    expect_cycle("R2 pass-through again", 16);
  endtask

  task automatic t_mul4();
    write_sel(2'b00, 1'b1);
    expect_cycle("R6 old rate holds one more cycle", 16);
    expect_cycle("R4 x4 cycle", 4);
    expect_cycle("R4 x4 cycle again", 4);
  endtask

  task automatic t_mul2();
    write_sel(2'b00, 1'b0);
    expect_cycle("R6 x4 holds one more cycle", 4);
    expect_cycle("R5 x2 cycle", 8);
  endtask

  task automatic t_reserved();
    write_sel(2'b01, 1'b1);
    expect_cycle("R7 reserved ignored a", 8);
    expect_cycle("R7 reserved ignored b", 8);
    expect_cycle("R7 reserved ignored c", 8);
  endtask

  task automatic t_slow();
    write_sel(2'b11, 1'b0);
    expect_cycle("R6 x2 holds one more cycle", 8);
    expect_cycle("R8 slow cycle", 4096);
    write_sel(2'b10, 1'b0);
    expect_cycle("R6 slow holds one more cycle", 4096);
    expect_cycle("R2 back to pass-through", 16);
  endtask

  task automatic t_override();
    wait_end();
    @(negedge clk_ref);
    write_now(2'b00, 1'b1);
    @(negedge clk_ref);
    write_now(2'b00, 1'b0);
    expect_cycle("R9 override old rate", 16);
    expect_cycle("R9 last write wins", 8);
  endtask

  task automatic t_midreset();
    write_sel(2'b11, 1'b0);
    @(negedge clk_ref);
    do_reset();
    check(mc_state == 2'd0, "R1 state after mid-run reset", int'(mc_state), 0);
    expect_cycle("R1 default after reset a", 16);
    expect_cycle("R1 pending cleared by reset", 16);
    expect_cycle("R1 default after reset c", 16);
  endtask

  initial begin
    repeat (100000) @(posedge clk_ref);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_div = 2'b00; wr_mul4 = 1'b0;
    @(negedge clk_ref);
    t_reset();
    t_default();
    t_mul4();
    t_mul2();
    t_reserved();
    t_slow();
    t_override();
    t_midreset();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule